// File: doc/BRIEF.md
# Dual-Port Memory Mailbox Interrupt Controller

This block sits beside a two-port shared memory and turns accesses to two reserved words at the top of the address space into interrupt flags. Each side of the memory gets one interrupt. A side posts a message by writing the other side's mailbox word. That raises the interrupt toward the other side. The receiving side picks up the message by reading its own mailbox word, which drops its interrupt. The mailbox data itself is held in the memory and never passes through this block. The controller only watches the control strobes, the address and the contention busy signal of each side.

Both sides present active-low enable, write and output-enable strobes. The strobes are sampled on the rising clock edge, and the flag registers update on that same edge. A busy input per side comes from the contention arbiter, and while busy is active it blocks that side from posting and from picking up. The address width is a parameter. The top word of the space belongs to the right side and the word just below it belongs to the left side.

Top module: `mbx_irq_ctrl`

## Requirements
- R1: While the synchronous active-low reset is sampled low, both interrupt outputs are driven high (inactive) from the next clock edge on, whatever the other inputs do.
- R2: A left-side write (enable low, write low) to the all-ones address, with left busy high, drives the right interrupt low from the next clock edge.
- R3: A right-side write to the all-ones-minus-one address, with right busy high, drives the left interrupt low from the next clock edge.
- R4: A read by the owning side of its own mailbox (enable low, write high, output-enable low; right owns all-ones, left owns all-ones-minus-one), with that side's busy high, drives its interrupt high again from the next clock edge.
- R5: A side that reads the other side's mailbox leaves both interrupts unchanged.
- R6: A side whose busy input is low cannot raise the interrupt toward the other side by writing that side's mailbox.
- R7: A side whose busy input is low cannot clear its own interrupt by reading its own mailbox.
- R8: When a raise and a clear of the same interrupt are sampled on the same edge, the interrupt ends up low (asserted).
- R9: Accesses with enable high, accesses to any other address, reads with output-enable high, and a side writing its own mailbox all leave both interrupts unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all sampling and flag updates on its rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| lt_en_n | input | 1 | Left side enable, active low |
| lt_wr_n | input | 1 | Left side write strobe, low = write, high = read |
| lt_oe_n | input | 1 | Left side output enable, active low, needed for a read |
| lt_addr | input | ADDR_W | Left side word address |
| lt_busy_n | input | 1 | Left side contention busy from the arbiter, active low |
| rt_en_n | input | 1 | Right side enable, active low |
| rt_wr_n | input | 1 | Right side write strobe, low = write, high = read |
| rt_oe_n | input | 1 | Right side output enable, active low, needed for a read |
| rt_addr | input | ADDR_W | Right side word address |
| rt_busy_n | input | 1 | Right side contention busy from the arbiter, active low |
| lt_irq_n | output | 1 | Interrupt toward the left side, active low |
| rt_irq_n | output | 1 | Interrupt toward the right side, active low |

## Verification
The properties assume that every strobe, address and busy input is stable and has a known value at each rising edge. They also assume that a single edge is one complete access. The bench meets this by changing inputs only one time unit after a rising edge and by returning every strobe to idle between scenarios. Busy is treated as a plain gating level with no timing of its own relative to the strobes. So the stimulus drives busy together with the access it is meant to block, in the same cycle.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
   // Side indices used to pick per-side structure.
   localparam int unsigned NUM_SIDES = 2;
   localparam int unsigned SIDE_LT   = 0;
   localparam int unsigned SIDE_RT   = 1;

   // Qualified mailbox events decoded from one side's access.
   typedef struct packed {
      logic post;   // write to the peer's mailbox, not blocked by busy
      logic take;   // read of the own mailbox, not blocked by busy
   } mbx_evt_t;
endpackage

// File: rtl/mbx_port_dec.sv
module mbx_port_dec
   import mbx_pkg::*;
#(
   parameter int unsigned           ADDR_W    = 15,
   parameter logic [ADDR_W-1:0]     OWN_ADDR  = '1,
   parameter logic [ADDR_W-1:0]     PEER_ADDR = '0
) (
   input  logic              en_n,
   input  logic              wr_n,
   input  logic              oe_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic              busy_n,
   output mbx_evt_t          evt
);
   logic wr_cyc;
   logic rd_cyc;
   logic hit_own;
   logic hit_peer;

   always_comb begin
      wr_cyc   = !en_n && !wr_n;
      rd_cyc   = !en_n &&  wr_n && !oe_n;
      hit_own  = (addr == OWN_ADDR);
      hit_peer = (addr == PEER_ADDR);
      evt.post = wr_cyc && hit_peer && busy_n;
      evt.take = rd_cyc && hit_own  && busy_n;
   end
endmodule

// File: rtl/mbx_flag.sv
module mbx_flag (
   input  logic clk,
   input  logic rst_n,
   input  logic set,
   input  logic clr,
   output logic flag_q
);
   always_ff @(posedge clk) begin
      if (!rst_n)
         flag_q <= 1'b0;
      else if (set)
         flag_q <= 1'b1;   // raise wins over a coincident pickup
      else if (clr)
         flag_q <= 1'b0;
   end
endmodule

// File: rtl/mbx_irq_ctrl.sv
module mbx_irq_ctrl
   import mbx_pkg::*;
#(
   parameter int unsigned ADDR_W = 15
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              lt_en_n,
   input  logic              lt_wr_n,
   input  logic              lt_oe_n,
   input  logic [ADDR_W-1:0] lt_addr,
   input  logic              lt_busy_n,
   input  logic              rt_en_n,
   input  logic              rt_wr_n,
   input  logic              rt_oe_n,
   input  logic [ADDR_W-1:0] rt_addr,
   input  logic              rt_busy_n,
   output logic              lt_irq_n,
   output logic              rt_irq_n
);
   localparam logic [ADDR_W-1:0] RT_BOX = {ADDR_W{1'b1}};
   localparam logic [ADDR_W-1:0] LT_BOX = {{(ADDR_W-1){1'b1}}, 1'b0};

   generate
      if (ADDR_W < 2) begin : g_bad_width
         $error("mbx_irq_ctrl: ADDR_W must be at least 2 to hold two mailboxes");
      end
   endgenerate

   logic [NUM_SIDES-1:0] en_n_v;
   logic [NUM_SIDES-1:0] wr_n_v;
   logic [NUM_SIDES-1:0] oe_n_v;
   logic [NUM_SIDES-1:0] busy_n_v;
   logic [ADDR_W-1:0]    addr_v [NUM_SIDES];
   mbx_evt_t             evt_v  [NUM_SIDES];
   logic [NUM_SIDES-1:0] flag_v;

   always_comb begin
      en_n_v[SIDE_LT]   = lt_en_n;
      en_n_v[SIDE_RT]   = rt_en_n;
      wr_n_v[SIDE_LT]   = lt_wr_n;
      wr_n_v[SIDE_RT]   = rt_wr_n;
      oe_n_v[SIDE_LT]   = lt_oe_n;
      oe_n_v[SIDE_RT]   = rt_oe_n;
      busy_n_v[SIDE_LT] = lt_busy_n;
      busy_n_v[SIDE_RT] = rt_busy_n;
      addr_v[SIDE_LT]   = lt_addr;
      addr_v[SIDE_RT]   = rt_addr;
   end

   genvar g;
   generate
      for (g = 0; g < NUM_SIDES; g++) begin : g_side
         localparam logic [ADDR_W-1:0] OWN  = (g == SIDE_LT) ? LT_BOX : RT_BOX;
         localparam logic [ADDR_W-1:0] PEER = (g == SIDE_LT) ? RT_BOX : LT_BOX;
         localparam int unsigned       OTHER = NUM_SIDES - 1 - g;

         mbx_port_dec #(
            .ADDR_W    (ADDR_W),
            .OWN_ADDR  (OWN),
            .PEER_ADDR (PEER)
         ) i_dec (
            .en_n   (en_n_v[g]),
            .wr_n   (wr_n_v[g]),
            .oe_n   (oe_n_v[g]),
            .addr   (addr_v[g]),
            .busy_n (busy_n_v[g]),
            .evt    (evt_v[g])
         );

         // Flag g is raised by the other side's post and cleared by own take.
         mbx_flag i_flag (
            .clk    (clk),
            .rst_n  (rst_n),
            .set    (evt_v[OTHER].post),
            .clr    (evt_v[g].take),
            .flag_q (flag_v[g])
         );
      end
   endgenerate

   assign lt_irq_n = ~flag_v[SIDE_LT];
   assign rt_irq_n = ~flag_v[SIDE_RT];
endmodule

// File: rtl/mbx_irq_chk.sv
module mbx_irq_chk #(
   parameter int unsigned ADDR_W = 15
) (
   input logic              clk,
   input logic              rst_n,
   input logic              lt_en_n,
   input logic              lt_wr_n,
   input logic              lt_oe_n,
   input logic [ADDR_W-1:0] lt_addr,
   input logic              lt_busy_n,
   input logic              rt_en_n,
   input logic              rt_wr_n,
   input logic              rt_oe_n,
   input logic [ADDR_W-1:0] rt_addr,
   input logic              rt_busy_n,
   input logic              lt_irq_n,
   input logic              rt_irq_n
);
   localparam logic [ADDR_W-1:0] HI = {ADDR_W{1'b1}};
   localparam logic [ADDR_W-1:0] LO = {{(ADDR_W-1){1'b1}}, 1'b0};

   logic raise_rt, raise_lt, drop_rt, drop_lt;
   assign raise_rt = !lt_en_n && !lt_wr_n && (lt_addr == HI) && lt_busy_n;
   assign raise_lt = !rt_en_n && !rt_wr_n && (rt_addr == LO) && rt_busy_n;
   assign drop_rt  = !rt_en_n && rt_wr_n && !rt_oe_n && (rt_addr == HI) && rt_busy_n;
   assign drop_lt  = !lt_en_n && lt_wr_n && !lt_oe_n && (lt_addr == LO) && lt_busy_n;

   // R1: reset drives both outputs inactive on the following edge
   p_reset_idle_r1: assert property (@(posedge clk)
      !rst_n |=> (lt_irq_n && rt_irq_n));

   p_raise_rt_r2: assert property (@(posedge clk) disable iff (!rst_n)
      raise_rt |=> !rt_irq_n);

   p_raise_lt_r3: assert property (@(posedge clk) disable iff (!rst_n)
      raise_lt |=> !lt_irq_n);

   p_drop_rt_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (drop_rt && !raise_rt) |=> rt_irq_n);

   p_drop_lt_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (drop_lt && !raise_lt) |=> lt_irq_n);

   // R6 (with R9): no qualified raise means an idle flag stays idle
   p_no_raise_rt_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (rt_irq_n && !raise_rt) |=> rt_irq_n);

   p_no_raise_lt_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (lt_irq_n && !raise_lt) |=> lt_irq_n);

   // R7 (with R5): no qualified pickup means a pending flag stays pending
   p_hold_rt_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (!rt_irq_n && !drop_rt) |=> !rt_irq_n);

   p_hold_lt_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (!lt_irq_n && !drop_lt) |=> !lt_irq_n);

   p_raise_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (raise_rt && drop_rt) |=> !rt_irq_n);
endmodule

bind mbx_irq_ctrl mbx_irq_chk #(.ADDR_W(ADDR_W)) i_mbx_irq_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .lt_en_n   (lt_en_n),
   .lt_wr_n   (lt_wr_n),
   .lt_oe_n   (lt_oe_n),
   .lt_addr   (lt_addr),
   .lt_busy_n (lt_busy_n),
   .rt_en_n   (rt_en_n),
   .rt_wr_n   (rt_wr_n),
   .rt_oe_n   (rt_oe_n),
   .rt_addr   (rt_addr),
   .rt_busy_n (rt_busy_n),
   .lt_irq_n  (lt_irq_n),
   .rt_irq_n  (rt_irq_n)
);

// File: tb/test_mbx_irq_ctrl.sv
`timescale 1ns/1ps
module test_mbx_irq_ctrl;
   localparam int unsigned AW = 15;
   localparam logic [AW-1:0] HI = {AW{1'b1}};
   localparam logic [AW-1:0] LO = {{(AW-1){1'b1}}, 1'b0};

   logic clk = 1'b0;
   logic rst_n;
   logic lt_en_n, lt_wr_n, lt_oe_n, lt_busy_n;
   logic rt_en_n, rt_wr_n, rt_oe_n, rt_busy_n;
   logic [AW-1:0] lt_addr, rt_addr;
   logic lt_irq_n, rt_irq_n;

   int n_chk  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   always #2.5 clk = ~clk;

   mbx_irq_ctrl #(.ADDR_W(AW)) i_mbx_irq_ctrl (
      .clk(clk), .rst_n(rst_n),
      .lt_en_n(lt_en_n), .lt_wr_n(lt_wr_n), .lt_oe_n(lt_oe_n),
      .lt_addr(lt_addr), .lt_busy_n(lt_busy_n),
      .rt_en_n(rt_en_n), .rt_wr_n(rt_wr_n), .rt_oe_n(rt_oe_n),
      .rt_addr(rt_addr), .rt_busy_n(rt_busy_n),
      .lt_irq_n(lt_irq_n), .rt_irq_n(rt_irq_n)
   );

   task automatic check(input logic act, input logic exp, input string what);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %b expected %b", what, act, exp);
      end
   endtask

   task automatic idle();
      lt_en_n = 1; lt_wr_n = 1; lt_oe_n = 1; lt_busy_n = 1; lt_addr = '0;
      rt_en_n = 1; rt_wr_n = 1; rt_oe_n = 1; rt_busy_n = 1; rt_addr = '0;
   endtask

   // One edge: inputs already driven, sample 1 ns after the edge.
   task automatic step();
      @(posedge clk);
      #1;
   endtask

   task automatic lt_write(input logic [AW-1:0] a, input logic bsy_n);
      lt_en_n = 0; lt_wr_n = 0; lt_oe_n = 1; lt_addr = a; lt_busy_n = bsy_n;
   endtask
   task automatic lt_read(input logic [AW-1:0] a, input logic oe, input logic bsy_n);
      lt_en_n = 0; lt_wr_n = 1; lt_oe_n = oe; lt_addr = a; lt_busy_n = bsy_n;
   endtask
   task automatic rt_write(input logic [AW-1:0] a, input logic bsy_n);
      rt_en_n = 0; rt_wr_n = 0; rt_oe_n = 1; rt_addr = a; rt_busy_n = bsy_n;
   endtask
   task automatic rt_read(input logic [AW-1:0] a, input logic oe, input logic bsy_n);
      rt_en_n = 0; rt_wr_n = 1; rt_oe_n = oe; rt_addr = a; rt_busy_n = bsy_n;
   endtask

   task automatic do_reset();
      idle(); rst_n = 0; step(); step(); rst_n = 1;
   endtask

   task automatic t_reset();
      check(lt_irq_n, 1'b1, "R1 left idle after reset");
      check(rt_irq_n, 1'b1, "R1 right idle after reset");
      lt_write(HI, 1); rt_write(LO, 1); step(); idle();
      rst_n = 0; lt_write(HI, 1); step();
      check(lt_irq_n, 1'b1, "R1 reset clears left, overrides post");
      check(rt_irq_n, 1'b1, "R1 reset clears right, overrides post");
      idle(); rst_n = 1; step();
   endtask

   task automatic t_rt_cycle();
      lt_write(HI, 1); step(); idle();
      check(rt_irq_n, 1'b0, "R2 left post raises right");
      check(lt_irq_n, 1'b1, "R2 left stays idle");
      lt_read(HI, 0, 1); step(); idle();
      check(rt_irq_n, 1'b0, "R5 left reading right box keeps flag");
      rt_read(HI, 0, 1); step(); idle();
      check(rt_irq_n, 1'b1, "R4 right pickup clears right");
   endtask

   task automatic t_lt_cycle();
      rt_write(LO, 1); step(); idle();
      check(lt_irq_n, 1'b0, "R3 right post raises left");
      check(rt_irq_n, 1'b1, "R3 right stays idle");
      rt_read(LO, 0, 1); step(); idle();
      check(lt_irq_n, 1'b0, "R5 right reading left box keeps flag");
      lt_read(LO, 0, 1); step(); idle();
      check(lt_irq_n, 1'b1, "R4 left pickup clears left");
   endtask

   task automatic t_busy();
      lt_write(HI, 0); step(); idle();
      check(rt_irq_n, 1'b1, "R6 busy left cannot raise right");
      rt_write(LO, 0); step(); idle();
      check(lt_irq_n, 1'b1, "R6 busy right cannot raise left");
      lt_write(HI, 1); rt_write(LO, 1); step(); idle();
      rt_read(HI, 0, 0); step(); idle();
      check(rt_irq_n, 1'b0, "R7 busy right cannot clear right");
      lt_read(LO, 0, 0); step(); idle();
      check(lt_irq_n, 1'b0, "R7 busy left cannot clear left");
      rt_read(HI, 0, 1); lt_read(LO, 0, 1); step(); idle();
      check(rt_irq_n, 1'b1, "R4 right clears once busy drops");
      check(lt_irq_n, 1'b1, "R4 left clears once busy drops");
   endtask

   task automatic t_raise_wins();
      lt_write(HI, 1); rt_read(HI, 0, 1); step(); idle();
      check(rt_irq_n, 1'b0, "R8 raise beats pickup from idle");
      lt_write(HI, 1); rt_read(HI, 0, 1); step(); idle();
      check(rt_irq_n, 1'b0, "R8 raise beats pickup while pending");
      rt_write(LO, 1); lt_read(LO, 0, 1); step(); idle();
      check(lt_irq_n, 1'b0, "R8 raise beats pickup on left");
      rt_read(HI, 0, 1); lt_read(LO, 0, 1); step(); idle();
   endtask

   task automatic t_ignored();
      lt_write(HI, 1); lt_en_n = 1; step(); idle();
      check(rt_irq_n, 1'b1, "R9 disabled write does not raise");
      lt_write(HI - 2, 1); rt_write(15'h0000, 1); step(); idle();
      check(rt_irq_n, 1'b1, "R9 other address left write");
      check(lt_irq_n, 1'b1, "R9 other address right write");
      rt_write(HI, 1); lt_write(LO, 1); step(); idle();
      check(rt_irq_n, 1'b1, "R9 right writing own box");
      check(lt_irq_n, 1'b1, "R9 left writing own box");
      lt_write(HI, 1); step(); idle();
      rt_read(HI, 1, 1); step(); idle();
      check(rt_irq_n, 1'b0, "R9 read without output enable keeps flag");
      rt_read(HI, 0, 1); rt_en_n = 1; step(); idle();
      check(rt_irq_n, 1'b0, "R9 disabled read keeps flag");
      rt_read(HI, 0, 1); step(); idle();
      check(rt_irq_n, 1'b1, "R4 proper pickup after ignored reads");
   endtask

   initial begin
      #100000;
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      do_reset();
      step();
      t_reset();
      t_rt_cycle();
      t_lt_cycle();
      t_busy();
      t_raise_wins();
      t_ignored();
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule